// File: doc/BRIEF.md
# Line-Aliasing Outstanding Request Tracker

This block admits memory requests from a core and tracks those still in flight, one entry per cache line. Each request carries a type code and a byte address. The block reduces the address to a line address by dropping the offset bits. It then sorts the request into a read class or a write class and makes one of three decisions in the same cycle:

- issue the request and record it,
- reject it as aliased because the same line is already in flight, so the requester must retry later,
- reject it because the tracker is full.

Every accepted entry stores the cycle on which it was issued. A completion input names a line and a class. It retires the matching entry and reports how many cycles the request waited. Four counters record how often each kind of same-line conflict caused a rejection. A completion that finds no entry sets a sticky error flag and leaves the tables unchanged.

Top module: `line_alias_tracker`

## Requirements
- R1: Type codes 0 (load) and 1 (instruction fetch) are read-class. Every other 4-bit code is write-class: 2 store, 3 RMW read, 4 RMW write, 5 linked load, 6 conditional store, 7 locked RMW read, 8 locked RMW write, 9 flush, and 10 to 15 treated the same way. The line address is `req_addr` shifted right by log2(LINE_BYTES) bits, so requests that differ only in offset bits refer to the same line.
- R2: A request made while `outstanding` is at or above MAX_OUT gets status 3 (full). It creates no entry and changes no counter. `outstanding` never exceeds MAX_OUT.
- R3: A write-class request to a line with an outstanding read entry gets status 2 (aliased), and `stall_st_ld` increments.
- R4: A write-class request to a line with an outstanding write entry, and no read entry, gets status 2, and `stall_st_st` increments.
- R5: A read-class request to a line with an outstanding write entry gets status 2, and `stall_ld_st` increments.
- R6: A read-class request to a line with an outstanding read entry, and no write entry, gets status 2, and `stall_ld_ld` increments.
- R7: Any other request gets status 1 (issued). It enters the table of its class, and `outstanding` rises by one on the next cycle. With no request the status is 0.
- R8: A completion with `cmp_is_write` at 0 retires the read entry for `cmp_line`, and with 1 retires the write entry for that line. `outstanding` falls by one and always equals the number of valid entries.
- R9: On a retiring completion, `lat_valid` is high in the same cycle, and `lat_cycles` holds the current cycle minus the issue cycle (modulo 2^TIME_W), but only when that difference is non-zero.
- R10: A completion with no matching entry in its class table sets `proto_err`. The flag stays set until reset, and the completion changes no entry.
- R11: A request and a completion in the same cycle are both handled. The full check and the alias checks see the tables as they stood before that completion.
- R12: With SATURATE set, each stall counter holds at its maximum value rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_type | input | 4 | Request type code |
| req_addr | input | ADDR_W | Request byte address |
| req_status | output | 2 | 0 none, 1 issued, 2 aliased, 3 full (combinational) |
| cmp_valid | input | 1 | Completion present this cycle |
| cmp_is_write | input | 1 | Completion class: 1 write, 0 read |
| cmp_line | input | ADDR_W-log2(LINE_BYTES) | Line address being completed |
| lat_valid | output | 1 | Retirement with non-zero latency this cycle |
| lat_cycles | output | TIME_W | Cycles between issue and completion |
| outstanding | output | clog2(MAX_OUT+1) | Number of valid entries |
| proto_err | output | 1 | Sticky unmatched-completion flag |
| stall_st_ld | output | STAT_W | Write rejected on an outstanding read |
| stall_st_st | output | STAT_W | Write rejected on an outstanding write |
| stall_ld_st | output | STAT_W | Read rejected on an outstanding write |
| stall_ld_ld | output | STAT_W | Read rejected on an outstanding read |

## Verification
The assertions assume that the requester never needs more than MAX_OUT slots in one table. This holds because the full check bounds the total count. They also assume that completions may arrive for lines that are not tracked. So the invariants on count and uniqueness must hold even when the requester misbehaves. The stimulus mixes directed sequences with a long pseudo-random phase over six lines and all sixteen type codes. That phase sends many completions that match nothing, and it revisits the same lines often enough that every alias pairing, the full condition and the same-cycle overlap occur many times.

// File: rtl/lat_pkg.sv
package lat_pkg;
   localparam logic [3:0] KIND_LOAD   = 4'd0;
   localparam logic [3:0] KIND_IFETCH = 4'd1;

   typedef enum logic [1:0] {
      ST_NONE   = 2'd0,
      ST_ISSUED = 2'd1,
      ST_ALIAS  = 2'd2,
      ST_FULL   = 2'd3
   } req_status_e;

   localparam int STALL_ST_LD = 0;
   localparam int STALL_ST_ST = 1;
   localparam int STALL_LD_ST = 2;
   localparam int STALL_LD_LD = 3;
   localparam int NUM_STALL   = 4;

   // R1: only load and fetch are read-class
   function automatic logic is_write_class(input logic [3:0] kind);
      return !(kind == KIND_LOAD || kind == KIND_IFETCH);
   endfunction
endpackage

// File: rtl/lat_table.sv
module lat_table #(
   parameter int DEPTH  = 4,
   parameter int LINE_W = 26,
   parameter int TIME_W = 16,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_W-1:0] look_line,
   output logic              look_hit,
   input  logic              alloc_en,
   input  logic [TIME_W-1:0] alloc_time,
   input  logic              free_en,
   input  logic [LINE_W-1:0] free_line,
   output logic              free_hit,
   output logic [TIME_W-1:0] free_time,
   output logic [CW-1:0]     occ
);
   logic [DEPTH-1:0]  vld;
   logic [LINE_W-1:0] tag  [DEPTH];
   logic [TIME_W-1:0] stamp[DEPTH];
   logic [DEPTH-1:0]  look_vec, free_vec;
   logic [IW-1:0]     slot;
   logic              has_room;

   always_comb begin
      free_time = '0;
      slot      = '0;
      has_room  = 1'b0;
      occ       = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         look_vec[i] = vld[i] && (tag[i] == look_line);
         free_vec[i] = vld[i] && (tag[i] == free_line);
         if (free_vec[i]) free_time = free_time | stamp[i];
         if (!vld[i]) begin
            slot     = IW'(i);
            has_room = 1'b1;
         end
         occ = occ + CW'(vld[i]);
      end
   end
   assign look_hit = |look_vec;
   assign free_hit = |free_vec;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[g]   <= 1'b0;
            tag[g]   <= '0;
            stamp[g] <= '0;
         end else if (alloc_en && slot == IW'(g) && !vld[g]) begin
            vld[g]   <= 1'b1;
            tag[g]   <= look_line;
            stamp[g] <= alloc_time;
         end else if (free_en && free_vec[g]) begin
            vld[g] <= 1'b0;
         end
      end
   end

   // R7: alias filtering upstream keeps each line in at most one entry
   p_unique_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(look_vec) && $onehot0(free_vec));
   // R2: the full check upstream guarantees a free slot on allocation
   p_alloc_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> has_room);
endmodule

// File: rtl/lat_stat_ctr.sv
module lat_stat_ctr #(
   parameter int W        = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] q
);
   logic step;
   if (SATURATE) begin : g_sat
      assign step = inc && (q != '1);
   end else begin : g_wrap
      assign step = inc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (step) q <= q + W'(1);
   end

   if (SATURATE) begin : g_chk
      // R12: a saturated counter never wraps to zero
      p_no_wrap_r12: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(q) == '1) |-> (q == '1));
   end
endmodule

// File: rtl/line_alias_tracker.sv
module line_alias_tracker
   import lat_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int MAX_OUT    = 4,
   parameter int TIME_W     = 16,
   parameter int STAT_W     = 16,
   parameter bit SATURATE   = 1'b1,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_W    = ADDR_W - OFF_W,
   localparam int CW        = $clog2(MAX_OUT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [3:0]        req_type,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [1:0]        req_status,
   input  logic              cmp_valid,
   input  logic              cmp_is_write,
   input  logic [LINE_W-1:0] cmp_line,
   output logic              lat_valid,
   output logic [TIME_W-1:0] lat_cycles,
   output logic [CW-1:0]     outstanding,
   output logic              proto_err,
   output logic [STAT_W-1:0] stall_st_ld,
   output logic [STAT_W-1:0] stall_st_st,
   output logic [STAT_W-1:0] stall_ld_st,
   output logic [STAT_W-1:0] stall_ld_ld
);
   if (MAX_OUT < 1) begin : g_bad_depth
      $error("MAX_OUT must be at least one");
   end
   if (LINE_BYTES < 1 || (1 << OFF_W) != LINE_BYTES || OFF_W >= ADDR_W) begin : g_bad_line
      $error("LINE_BYTES must be a power of two below the address span");
   end
   if (TIME_W < 2 || STAT_W < 1) begin : g_bad_width
      $error("TIME_W and STAT_W are too narrow");
   end

   logic [LINE_W-1:0] req_line;
   logic              unused_offset;
   logic              wcls, full, accept, retire;
   logic              rd_hit, wr_hit, rd_fhit, wr_fhit;
   logic [TIME_W-1:0] rd_ftime, wr_ftime, issue_t, now, lat;
   logic [CW-1:0]     rd_occ, wr_occ;
   logic [NUM_STALL-1:0] bump;
   logic [STAT_W-1:0] stall_q[NUM_STALL];
   req_status_e       st;

   assign req_line      = req_addr[ADDR_W-1:OFF_W];
   assign unused_offset = ^req_addr[OFF_W-1:0];
   assign wcls          = is_write_class(req_type);
   assign full          = outstanding >= CW'(MAX_OUT);

   // R2..R7: decisions taken against the tables as they stood at cycle start
   always_comb begin
      st     = ST_NONE;
      accept = 1'b0;
      bump   = '0;
      if (req_valid) begin
         if (full) begin
            st = ST_FULL;
         end else if (wcls) begin
            if (rd_hit)      begin st = ST_ALIAS; bump[STALL_ST_LD] = 1'b1; end
            else if (wr_hit) begin st = ST_ALIAS; bump[STALL_ST_ST] = 1'b1; end
            else             begin st = ST_ISSUED; accept = 1'b1; end
         end else begin
            if (wr_hit)      begin st = ST_ALIAS; bump[STALL_LD_ST] = 1'b1; end
            else if (rd_hit) begin st = ST_ALIAS; bump[STALL_LD_LD] = 1'b1; end
            else             begin st = ST_ISSUED; accept = 1'b1; end
         end
      end
   end
   assign req_status = st;

   lat_table #(.DEPTH(MAX_OUT), .LINE_W(LINE_W), .TIME_W(TIME_W)) u_rd_tab (
      .clk, .rst_n, .look_line(req_line), .look_hit(rd_hit),
      .alloc_en(accept && !wcls), .alloc_time(now),
      .free_en(cmp_valid && !cmp_is_write), .free_line(cmp_line),
      .free_hit(rd_fhit), .free_time(rd_ftime), .occ(rd_occ));

   lat_table #(.DEPTH(MAX_OUT), .LINE_W(LINE_W), .TIME_W(TIME_W)) u_wr_tab (
      .clk, .rst_n, .look_line(req_line), .look_hit(wr_hit),
      .alloc_en(accept && wcls), .alloc_time(now),
      .free_en(cmp_valid && cmp_is_write), .free_line(cmp_line),
      .free_hit(wr_fhit), .free_time(wr_ftime), .occ(wr_occ));

   // R8/R9: retirement and latency
   assign retire     = cmp_valid && (cmp_is_write ? wr_fhit : rd_fhit);
   assign issue_t    = cmp_is_write ? wr_ftime : rd_ftime;
   assign lat        = now - issue_t;
   assign lat_valid  = retire && (lat != '0);
   assign lat_cycles = lat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         now         <= '0;
         outstanding <= '0;
         proto_err   <= 1'b0;
      end else begin
         now <= now + TIME_W'(1);
         if (accept && !retire)      outstanding <= outstanding + CW'(1);
         else if (!accept && retire) outstanding <= outstanding - CW'(1);
         if (cmp_valid && !retire)   proto_err <= 1'b1;   // R10
      end
   end

   for (genvar k = 0; k < NUM_STALL; k++) begin : g_stall
      lat_stat_ctr #(.W(STAT_W), .SATURATE(SATURATE)) u_ctr (
         .clk, .rst_n, .inc(bump[k]), .q(stall_q[k]));
   end
   assign stall_st_ld = stall_q[STALL_ST_LD];
   assign stall_st_st = stall_q[STALL_ST_ST];
   assign stall_ld_st = stall_q[STALL_LD_ST];
   assign stall_ld_ld = stall_q[STALL_LD_LD];

   p_count_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (CW+1)'(outstanding) == (CW+1)'(rd_occ) + (CW+1)'(wr_occ));
   p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding <= CW'(MAX_OUT));
   p_issue_grows_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_status == ST_ISSUED && !retire) |=> outstanding == $past(outstanding) + CW'(1));
   p_retire_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (retire && req_status != ST_ISSUED) |=> outstanding == $past(outstanding) - CW'(1));
   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);
endmodule

// File: tb/line_alias_tracker_test.sv
module line_alias_tracker_test;
   localparam int ADDR_W = 32, LINE_BYTES = 64, MAX_OUT = 4, TIME_W = 16, STAT_W = 3;
   localparam int LINE_W = ADDR_W - 6;
   localparam int CW = $clog2(MAX_OUT + 1);

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;

   logic              req_valid = 0, cmp_valid = 0, cmp_is_write = 0;
   logic [3:0]        req_type = 0;
   logic [ADDR_W-1:0] req_addr = 0;
   logic [LINE_W-1:0] cmp_line = 0;
   logic [1:0]        req_status;
   logic              lat_valid, proto_err;
   logic [TIME_W-1:0] lat_cycles;
   logic [CW-1:0]     outstanding;
   logic [STAT_W-1:0] s_stld, s_stst, s_ldst, s_ldld;

   line_alias_tracker #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .MAX_OUT(MAX_OUT),
      .TIME_W(TIME_W), .STAT_W(STAT_W), .SATURATE(1'b1)) uut (
      .clk, .rst_n, .req_valid, .req_type, .req_addr, .req_status,
      .cmp_valid, .cmp_is_write, .cmp_line, .lat_valid, .lat_cycles,
      .outstanding, .proto_err, .stall_st_ld(s_stld), .stall_st_st(s_stst),
      .stall_ld_st(s_ldst), .stall_ld_ld(s_ldld));

   // behavioural reference model
   int rd_l[$], rd_t[$], wr_l[$], wr_t[$];
   int m_st[4];
   bit m_err = 0;
   int cyc = 0;
   int checks = 0, fails = 0;
   bit done = 0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(bit rv, int rt, int ra, bit cv, bit cw, int cl);
      int line, es, lat;
      bit wc, rh, wh, hit, acc;
      int kidx;
      string tag;
      @(negedge clk);
      req_valid = rv; req_type = 4'(rt); req_addr = ADDR_W'(ra);
      cmp_valid = cv; cmp_is_write = cw; cmp_line = LINE_W'(cl);
      #2;
      chk("R8 outstanding", int'(outstanding), rd_l.size() + wr_l.size());
      chk("R10 proto_err", int'(proto_err), int'(m_err));
      chk("R3 stall_st_ld", int'(s_stld), m_st[0]);
      chk("R4 stall_st_st", int'(s_stst), m_st[1]);
      chk("R5 stall_ld_st", int'(s_ldst), m_st[2]);
      chk("R6 stall_ld_ld", int'(s_ldld), m_st[3]);
      // R1: line address and class
      line = ra >>> 6;
      wc = !(rt == 0 || rt == 1);
      rh = 0; wh = 0;
      foreach (rd_l[i]) if (rd_l[i] == line) rh = 1;
      foreach (wr_l[i]) if (wr_l[i] == line) wh = 1;
      es = 0; acc = 0; kidx = -1; tag = "R7 status";
      if (rv) begin
         if (rd_l.size() + wr_l.size() >= MAX_OUT) begin es = 3; tag = "R2 status"; end
         else if (wc && rh) begin es = 2; kidx = 0; tag = "R3 status"; end
         else if (wc && wh) begin es = 2; kidx = 1; tag = "R4 status"; end
         else if (!wc && wh) begin es = 2; kidx = 2; tag = "R5 status"; end
         else if (!wc && rh) begin es = 2; kidx = 3; tag = "R6 status"; end
         else begin es = 1; acc = 1; end
      end
      chk(tag, int'(req_status), es);
      // completion against pre-state (R11)
      hit = 0; lat = 0;
      if (cv) begin
         if (cw) begin
            foreach (wr_l[i]) if (wr_l[i] == cl) begin hit = 1; lat = (cyc - wr_t[i]) & 16'hFFFF; end
         end else begin
            foreach (rd_l[i]) if (rd_l[i] == cl) begin hit = 1; lat = (cyc - rd_t[i]) & 16'hFFFF; end
         end
      end
      chk("R9 lat_valid", int'(lat_valid), int'(hit && lat != 0));
      if (hit && lat != 0) chk("R9 lat_cycles", int'(lat_cycles), lat);
      // update model
      if (kidx >= 0 && m_st[kidx] < 7) m_st[kidx]++;
      if (cv && !hit) m_err = 1;
      if (hit) begin
         if (cw) begin
            foreach (wr_l[i]) if (wr_l[i] == cl) begin wr_l.delete(i); wr_t.delete(i); break; end
         end else begin
            foreach (rd_l[i]) if (rd_l[i] == cl) begin rd_l.delete(i); rd_t.delete(i); break; end
         end
      end
      if (acc) begin
         if (wc) begin wr_l.push_back(line); wr_t.push_back(cyc); end
         else    begin rd_l.push_back(line); rd_t.push_back(cyc); end
      end
      cyc++;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      idle(1);                                   // reset state
      // R7 and R1: loads and stores on distinct lines
      step(1, 0, 32'h040, 0, 0, 0);
      step(1, 2, 32'h080, 0, 0, 0);
      // R1: offset bits ignored; fetch on line 1 aliases load on line 1 (R6)
      step(1, 1, 32'h07F, 0, 0, 0);
      // R3: store on outstanding read; R5: load on outstanding write
      step(1, 9, 32'h041, 0, 0, 0);
      step(1, 0, 32'h0BF, 0, 0, 0);
      // R4: write on write
      step(1, 6, 32'h080, 0, 0, 0);
      idle(2);
      // R9: retire read of line 1 with latency; R8 count falls
      step(0, 0, 0, 1, 0, 1);
      // R10: completion of wrong class on line 2 has no match
      step(0, 0, 0, 1, 0, 2);
      // fill to R2 full
      step(1, 5, 32'h100, 0, 0, 0);
      step(1, 3, 32'h140, 0, 0, 0);
      step(1, 0, 32'h180, 0, 0, 0);
      step(1, 0, 32'h1C0, 0, 0, 0);
      // R11: full check uses count before same-cycle retirement
      step(1, 0, 32'h1C0, 1, 1, 2);
      // R11: alias check sees line 4 before its retirement
      step(1, 2, 32'h100, 1, 1, 4);
      step(1, 2, 32'h100, 0, 0, 0);
      // R12: saturation of the load-on-load counter
      for (int i = 0; i < 10; i++) step(1, 1, 32'h180, 0, 0, 0);
      // drain
      step(0, 0, 0, 1, 1, 4);
      step(0, 0, 0, 1, 1, 5);
      step(0, 0, 0, 1, 0, 6);
      idle(1);
      // mixed pseudo-random phase
      for (int i = 0; i < 3000; i++)
         step($urandom % 2, $urandom % 16, (($urandom % 6) << 6) | ($urandom % 64),
              ($urandom % 3) == 0, $urandom % 2, $urandom % 6);
      idle(2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule